// File: doc/BRIEF.md
# Burst Offset Sequencer

This block produces the low two bits of the address for a four-beat burst memory access. When a burst starts, it takes a starting offset from the external address. After that it moves to the next offset on each clock where the active-low advance input is asserted. When advance is released the burst is suspended and the current offset is presented again. A static order input selects the sequence: counting upward modulo four, or XOR-combining the start with a beat number.

Two active-low start strobes are provided, one per requester. Either one, or both, begins a new burst. A load always wins over an advance in the same cycle. Internally the block keeps the start offset and a beat count. It forms the presented offset from these two registers, so both orders share the same storage. The offset and the beat index are registered outputs.

Top module: `burst_offset_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `ofs_o` and `beat_o` become 0 after that edge.
- R2: After an edge at which a load occurs, `ofs_o` equals the `addr_i` value sampled at that edge and `beat_o` is 0.
- R3: When a load and `adv_n` low occur at the same edge, the load wins: `ofs_o` equals `addr_i` and `beat_o` is 0.
- R4: A load occurs when `strb_a_n` is 0, when `strb_b_n` is 0, or when both are 0.
- R5: When no load occurs and `adv_n` is 1, `ofs_o` and `beat_o` keep their values at that edge.
- R6: With `order_i` = 0 (linear), `ofs_o` = (start + `beat_o`) mod 4. From start 01 the sequence is 01, 10, 11, 00.
- R7: With `order_i` = 1 (interleaved), `ofs_o` = start XOR `beat_o`. From start 01 the sequence is 01, 00, 11, 10.
- R8: When no load occurs and `adv_n` is 0, `beat_o` increases by one modulo 4.
- R9: The fourth advance after a load brings `ofs_o` back to the loaded start and `beat_o` back to 0. This holds in both orders.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| strb_a_n | input | 1 | First start strobe, active low |
| strb_b_n | input | 1 | Second start strobe, active low |
| adv_n | input | 1 | Advance to the next beat, active low |
| addr_i | input | OFS_W | Starting offset taken at a load |
| ofs_o | output | OFS_W | Current burst offset (registered) |
| beat_o | output | OFS_W | Beats advanced since the load (registered) |

## Verification
The hardest case to reach is a wrap that has suspend cycles mixed into it, reached from every start offset in both orders. A missing hold, or a beat that steps twice, only shows up once the full four-advance cycle has been completed. The stimulus sweeps all four starts in each order, with alternating strobes. It advances five times with a hold between the second and third advance. It then checks the offset and the beat after every edge against a value the bench computes arithmetically. Separate cases put a strobe and an advance in the same cycle, and assert both strobes together.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bsq_start_reg.sv
module bsq_start_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] addr,
  output logic [W-1:0] start_d,
  output logic [W-1:0] start_q
);
  always_comb start_d = load ? addr : start_q;

  always_ff @(posedge clk) begin
    if (rst) start_q <= '0;
    else     start_q <= start_d;
  end

  assert_start_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> start_q == $past(addr));
  assert_start_keep_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(start_q));
endmodule

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] beat_d,
  output logic [W-1:0] beat_q
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    if (load)      beat_d = '0;
    else if (step) beat_d = beat_q + ONE;
    else           beat_d = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_d;
  end

  assert_beat_clear_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> beat_q == '0);
  assert_beat_step_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && step) |=> beat_q == $past(beat_q) + ONE);
  assert_beat_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(beat_q));
endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map
  import bsq_pkg::*;
#(
  parameter int W = 2
) (
  input  order_e       order,
  input  logic [W-1:0] start,
  input  logic [W-1:0] beat,
  output logic [W-1:0] ofs
);
  always_comb begin
    if (order == ORD_INTERLEAVE) ofs = start ^ beat;
    else                         ofs = start + beat;
  end
endmodule

// File: rtl/burst_offset_seq.sv
module burst_offset_seq
  import bsq_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             order_i,
  input  logic             strb_a_n,
  input  logic             strb_b_n,
  input  logic             adv_n,
  input  logic [OFS_W-1:0] addr_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic [OFS_W-1:0] beat_o
);
  localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

  logic             load, step;
  order_e           order;
  logic [OFS_W-1:0] start_d, start_q, beat_d, beat_q, ofs_d;

  assign load  = !strb_a_n || !strb_b_n;
  assign step  = !adv_n;
  assign order = order_e'(order_i);

  bsq_start_reg #(.W(OFS_W)) u_start (
    .clk(clk), .rst(rst), .load(load), .addr(addr_i),
    .start_d(start_d), .start_q(start_q));

  bsq_beat_ctr #(.W(OFS_W)) u_beat (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .beat_d(beat_d), .beat_q(beat_q));

  bsq_order_map #(.W(OFS_W)) u_map (
    .order(order), .start(start_d), .beat(beat_d), .ofs(ofs_d));

  always_ff @(posedge clk) begin
    if (rst) ofs_o <= '0;
    else     ofs_o <= ofs_d;
  end

  assign beat_o = beat_q;

  assert_ofs_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> ofs_o == $past(addr_i));
  assert_ofs_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && !step && $stable(order_i)) |=> $stable(ofs_o));
  assert_lin_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && step && !order_i && $stable(order_i)) |=> ofs_o == $past(ofs_o) + ONE);
  assert_ilv_step_R7: assert property (@(posedge clk) disable iff (rst)
    (!load && step && order_i && $stable(order_i))
      |=> (ofs_o ^ $past(ofs_o)) == (beat_o ^ $past(beat_o)));
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (ofs_o == '0 && beat_o == '0));
endmodule

// File: tb/test_burst_offset_seq.sv
module test_burst_offset_seq;
  localparam int W = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         order_i = 1'b1;
  logic         strb_a_n = 1'b1;
  logic         strb_b_n = 1'b1;
  logic         adv_n = 1'b1;
  logic [W-1:0] addr_i = '0;
  logic [W-1:0] ofs_o, beat_o;

  int total = 0;
  int bad = 0;
  logic [W-1:0] e_start, e_beat;

  always #10 clk = ~clk;

  burst_offset_seq #(.OFS_W(W)) i_burst_offset_seq (
    .clk(clk), .rst(rst), .order_i(order_i), .strb_a_n(strb_a_n),
    .strb_b_n(strb_b_n), .adv_n(adv_n), .addr_i(addr_i),
    .ofs_o(ofs_o), .beat_o(beat_o));

  function automatic logic [W-1:0] exp_ofs(input logic ord, input logic [W-1:0] s,
                                           input logic [W-1:0] b);
    return ord ? (s ^ b) : W'(s + b);
  endfunction

  task automatic check(input string req, input logic [W-1:0] eo, input logic [W-1:0] eb);
    total++;
    if (ofs_o !== eo || beat_o !== eb) begin
      bad++;
      $display("FAIL %s: ofs=%0d beat=%0d expected ofs=%0d beat=%0d",
               req, ofs_o, beat_o, eo, eb);
    end
  endtask

  // drive at negedge, edge, then sample 1 ns after the edge
  task automatic cyc(input logic a_n, input logic b_n, input logic v_n, input logic [W-1:0] ad);
    @(negedge clk);
    strb_a_n = a_n; strb_b_n = b_n; adv_n = v_n; addr_i = ad;
    @(posedge clk);
    #1;
    if (!a_n || !b_n) begin
      e_start = ad; e_beat = '0;
    end else if (!v_n) begin
      e_beat = W'(e_beat + 1);
    end
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: ofs=%0d beat=%0d expected completion", ofs_o, beat_o);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    e_start = '0; e_beat = '0;
    strb_a_n = 1'b0; adv_n = 1'b0; addr_i = 2'd3;
    repeat (2) @(posedge clk);
    #1;
    check("R1", '0, '0);
    @(negedge clk);
    rst = 1'b0; strb_a_n = 1'b1; adv_n = 1'b1;

    for (int ord = 0; ord < 2; ord++) begin
      order_i = ord[0];
      for (int s = 0; s < 4; s++) begin
        if (s[0]) cyc(1'b1, 1'b0, 1'b1, W'(s));
        else      cyc(1'b0, 1'b1, 1'b1, W'(s));
        check("R2_R4", W'(s), '0);
        for (int k = 1; k <= 5; k++) begin
          cyc(1'b1, 1'b1, 1'b0, W'(3 - s));
          if (ord == 0) check("R6_R8", exp_ofs(1'b0, W'(s), W'(k)), W'(k));
          else          check("R7_R8", exp_ofs(1'b1, W'(s), W'(k)), W'(k));
          if (k == 4) check("R9", W'(s), '0);
          if (k == 2) begin
            cyc(1'b1, 1'b1, 1'b1, W'(s + 1));
            check("R5", exp_ofs(ord[0], W'(s), W'(2)), W'(2));
            cyc(1'b1, 1'b1, 1'b1, W'(s + 2));
            check("R5", exp_ofs(ord[0], W'(s), W'(2)), W'(2));
          end
        end
        cyc(1'b0, 1'b1, 1'b0, W'(s ^ 2));
        check("R3", W'(s ^ 2), '0);
        cyc(1'b1, 1'b0, 1'b0, W'(s ^ 1));
        check("R3", W'(s ^ 1), '0);
        cyc(1'b0, 1'b0, 1'b1, W'(s));
        check("R4", W'(s), '0);
      end
    end

    // explicit sequences from start 01 in each order
    order_i = 1'b0;
    cyc(1'b0, 1'b1, 1'b1, 2'd1);
    cyc(1'b1, 1'b1, 1'b0, 2'd0); check("R6", 2'd2, 2'd1);
    cyc(1'b1, 1'b1, 1'b0, 2'd0); check("R6", 2'd3, 2'd2);
    cyc(1'b1, 1'b1, 1'b0, 2'd0); check("R6", 2'd0, 2'd3);
    order_i = 1'b1;
    cyc(1'b0, 1'b1, 1'b1, 2'd1);
    cyc(1'b1, 1'b1, 1'b0, 2'd0); check("R7", 2'd0, 2'd1);
    cyc(1'b1, 1'b1, 1'b0, 2'd0); check("R7", 2'd3, 2'd2);
    cyc(1'b1, 1'b1, 1'b0, 2'd0); check("R7", 2'd2, 2'd3);

    // reset in the middle of a burst
    @(negedge clk); rst = 1'b1; adv_n = 1'b0;
    @(posedge clk); #1;
    check("R1", '0, '0);
    @(negedge clk); rst = 1'b0; adv_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule